// File: doc/BRIEF.md
# HDLC Bit-Serial Transmit Framer

This block turns a byte-wide transmit queue into a bit-serial HDLC line signal. It reads entries from a show-ahead FIFO. Each entry holds one data byte and a tag that marks the last byte of a packet. The block sends one bit on each cycle in which the bit strobe is high. For each packet it adds an opening flag, a 16-bit frame check sequence and a closing flag. Inside data and FCS it inserts a zero after every run of five ones.

Between packets the line carries a link state, chosen by a two-bit selector: all ones, back-to-back flags, a go-ahead pattern, or a raw pass-through in which FIFO bytes go out unframed. A waiting packet starts only when the current link-state byte has finished. In go-ahead the packet waits until the selector is changed. If the FIFO runs dry before a tagged last byte has gone out, the frame is aborted with a run of ones.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While `tx_en` is low, `ser_out` is 1 and `fifo_rd` stays 0. The first byte slot after `tx_en` rises is always eight ones. Bytes go out least-significant bit first.
- R2: With `link_mode` = 0 (mark), the line idles on ones. When the FIFO holds data, the ones byte in progress completes, then flag 0x7E is sent, then the packet.
- R3: With `link_mode` = 1 (flag fill), flags 0x7E are sent back to back. When data waits, the flag in progress completes, one opening flag follows, then the packet.
- R4: With `link_mode` = 2 (go-ahead), the byte 0xFE repeats (a zero, then seven ones) and the FIFO is never read. After the selector changes to 0, the held packet is sent and the FIFO drains.
- R5: `fifo_rd` pulses for one cycle at a byte boundary, and only while `fifo_empty` is 0. The byte read is transmitted in the next byte slot.
- R6: After a byte whose `fifo_last` is 1, the FCS is sent. It is the ones complement of CRC-16 (reflected polynomial 0x8408, preset 0xFFFF) computed over the packet bytes, low byte first, each byte LSB first.
- R7: A closing flag follows the FCS. If the FIFO still holds data, one more flag is sent and the next packet starts. Otherwise the line returns to the selected link state.
- R8: After five consecutive ones of data or FCS, a zero is inserted, including just before the closing flag. No zero is ever inserted into flags, ones bytes, go-ahead bytes or raw bytes.
- R9: With `link_mode` = 3 (raw), FIFO bytes are sent unchanged, with no flags, FCS or zero insertion. The line carries ones when the FIFO is empty.
- R10: If the FIFO is empty after an untagged packet byte, eight ones are sent and the line returns to the selected link state.
- R11: Dropping `tx_en` mid-packet immediately forces `ser_out` to 1 and stops FIFO reads, whatever `bit_en` does.
- R12: `ser_out` changes only on cycles in which `bit_en` was high, while `tx_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| bit_en | input | 1 | One-cycle strobe per line bit |
| link_mode | input | 2 | Link state: 0 mark, 1 flag fill, 2 go-ahead, 3 raw |
| fifo_empty | input | 1 | FIFO holds no entry |
| fifo_data | input | 8 | Head entry data byte |
| fifo_last | input | 1 | Head entry is the last byte of a packet |
| fifo_rd | output | 1 | Pop the head entry |
| ser_out | output | 1 | Serial line output |

## Verification
The bench targets these corner cases:
- A data byte or FCS that ends on its fifth one. A design that skips this stuffing would let a false flag reach the closing-flag boundary.
- Byte 0x7E and runs of 0xFF inside packets. A design that stuffs the wrong units would corrupt the raw-mode bytes and the link patterns.
- A FIFO that runs dry without a tag. A design that misses this would send an FCS instead of the abort ones.
- Go-ahead with queued data. A design that leaks a read here would start a packet early.

Every stream is compared bit by bit against a model built from the requirements, under random strobe spacing.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  typedef enum logic [1:0] {
    LINK_MARK = 2'd0,
    LINK_FILL = 2'd1,
    LINK_GA   = 2'd2,
    LINK_RAW  = 2'd3
  } link_e;

  typedef enum logic [3:0] {
    U_MARK,
    U_FLAG,
    U_GA,
    U_RAW,
    U_OPEN,
    U_DATA,
    U_FCS_LO,
    U_FCS_HI,
    U_CLOSE
  } unit_e;

  localparam logic [7:0] PAT_FLAG = 8'h7E;
  localparam logic [7:0] PAT_MARK = 8'hFF;
  localparam logic [7:0] PAT_GA   = 8'hFE;

endpackage

// File: rtl/hdlc_tx_stuff.sv
module hdlc_tx_stuff #(
  parameter int unsigned RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic stuffable,
  input  logic bit_in,
  output logic stuff_now
);
  localparam int unsigned CW = $clog2(RUN + 1);

  logic [CW-1:0] run_q, run_d;

  assign stuff_now = (run_q == CW'(RUN));

  always_comb begin
    run_d = run_q;
    if (clr) begin
      run_d = '0;
    end else if (tick) begin
      if (stuff_now)                 run_d = '0;
      else if (stuffable && bit_in)  run_d = run_q + CW'(1);
      else                           run_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  // the run of ones never exceeds the limit (R8)
  assert_run_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= CW'(RUN));

  // an inserted zero restarts the run (R8)
  assert_stuff_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && stuff_now) |=> (run_q == '0));

endmodule

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs #(
  parameter int unsigned             W    = 16,
  parameter logic [W-1:0]            POLY = 16'h8408
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic         step,
  input  logic         din,
  output logic [W-1:0] crc_d
);
  logic [W-1:0] crc_q;
  logic         fb;

  assign fb = crc_q[0] ^ din;

  always_comb begin
    crc_d = crc_q;
    if (init)      crc_d = '1;
    else if (step) crc_d = (crc_q >> 1) ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '1;
    else        crc_q <= crc_d;
  end

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer #(
  parameter int unsigned              BYTE_W    = 8,
  parameter int unsigned              STUFF_RUN = 5,
  parameter logic [2*BYTE_W-1:0]      FCS_POLY  = 16'h8408
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              bit_en,
  input  logic [1:0]        link_mode,
  input  logic              fifo_empty,
  input  logic [BYTE_W-1:0] fifo_data,
  input  logic              fifo_last,
  output logic              fifo_rd,
  output logic              ser_out
);
  import hdlc_tx_pkg::*;

  localparam int unsigned FCS_W = 2 * BYTE_W;
  localparam int unsigned BCW   = $clog2(BYTE_W);

  // reset: asserted asynchronously, released synchronously
  logic [1:0] rs_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  link_e             mode;
  unit_e             unit_q, unit_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BCW-1:0]    bcnt_q, bcnt_d;
  logic              last_q, last_d;
  logic              ser_q, ser_d;
  logic              pop, tick, adv, boundary, have, stuff_now, stuffable, in_frame;
  logic [FCS_W-1:0]  crc_d;

  assign mode      = link_e'(link_mode);
  assign have      = !fifo_empty;
  assign tick      = tx_en && bit_en;
  assign adv       = tick && !stuff_now;
  assign boundary  = adv && (bcnt_q == BCW'(BYTE_W - 1));
  assign stuffable = (unit_q == U_DATA) || (unit_q == U_FCS_LO) || (unit_q == U_FCS_HI);
  assign in_frame  = stuffable;

  hdlc_tx_stuff #(.RUN(STUFF_RUN)) u_stuff (
    .clk(clk), .rst_n(rst_ns), .clr(!tx_en), .tick(tick),
    .stuffable(stuffable), .bit_in(sh_q[0]), .stuff_now(stuff_now)
  );

  hdlc_tx_fcs #(.W(FCS_W), .POLY(FCS_POLY)) u_fcs (
    .clk(clk), .rst_n(rst_ns), .init(!tx_en || !in_frame),
    .step(adv && (unit_q == U_DATA)), .din(sh_q[0]), .crc_d(crc_d)
  );

  always_comb begin
    unit_d = unit_q;
    sh_d   = sh_q;
    bcnt_d = bcnt_q;
    last_d = last_q;
    ser_d  = ser_q;
    pop    = 1'b0;
    if (!tx_en) begin
      unit_d = U_MARK;
      sh_d   = PAT_MARK;
      bcnt_d = '0;
      last_d = 1'b0;
      ser_d  = 1'b1;
    end else if (tick) begin
      ser_d = stuff_now ? 1'b0 : sh_q[0];
      if (!stuff_now) begin
        sh_d   = sh_q >> 1;
        bcnt_d = bcnt_q + BCW'(1);
        if (boundary) begin
          bcnt_d = '0;
          case (unit_q)
            U_OPEN: begin
              if (have) begin
                pop = 1'b1; unit_d = U_DATA; sh_d = fifo_data; last_d = fifo_last;
              end else begin
                unit_d = U_MARK; sh_d = PAT_MARK;
              end
            end
            U_DATA: begin
              if (last_q) begin
                unit_d = U_FCS_LO; sh_d = ~crc_d[BYTE_W-1:0];
              end else if (have) begin
                pop = 1'b1; sh_d = fifo_data; last_d = fifo_last;
              end else begin
                unit_d = U_MARK; sh_d = PAT_MARK;
              end
            end
            U_FCS_LO: begin
              unit_d = U_FCS_HI; sh_d = ~crc_d[FCS_W-1:BYTE_W];
            end
            U_FCS_HI: begin
              unit_d = U_CLOSE; sh_d = PAT_FLAG;
            end
            default: begin
              case (mode)
                LINK_GA: begin
                  unit_d = U_GA; sh_d = PAT_GA;
                end
                LINK_RAW: begin
                  if (have) begin
                    pop = 1'b1; unit_d = U_RAW; sh_d = fifo_data;
                  end else begin
                    unit_d = U_MARK; sh_d = PAT_MARK;
                  end
                end
                LINK_FILL: begin
                  unit_d = have ? U_OPEN : U_FLAG; sh_d = PAT_FLAG;
                end
                default: begin
                  unit_d = have ? U_OPEN : U_MARK;
                  sh_d   = have ? PAT_FLAG : PAT_MARK;
                end
              endcase
            end
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      unit_q <= U_MARK;
      sh_q   <= PAT_MARK;
      bcnt_q <= '0;
      last_q <= 1'b0;
      ser_q  <= 1'b1;
    end else begin
      unit_q <= unit_d;
      sh_q   <= sh_d;
      bcnt_q <= bcnt_d;
      last_q <= last_d;
      ser_q  <= ser_d;
    end
  end

  assign fifo_rd = pop;
  assign ser_out = ser_q;

  assert_rd_has_data_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    fifo_rd |-> !fifo_empty);

  assert_ga_no_read_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    (mode == LINK_GA && unit_q != U_OPEN && unit_q != U_DATA) |-> !fifo_rd);

  assert_abort_on_dry_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    (boundary && unit_q == U_DATA && !last_q && fifo_empty) |=> (unit_q == U_MARK));

  assert_disabled_mark_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    !tx_en |=> (ser_out && !fifo_rd));

  assert_hold_between_R12: assert property (@(posedge clk) disable iff (!rst_ns)
    (tx_en && !bit_en) |=> $stable(ser_out));

endmodule

// File: tb/sim_hdlc_tx_framer.sv
module sim_hdlc_tx_framer;

  logic       clk = 1'b0;
  logic       rst_n, tx_en, bit_en, fifo_empty, fifo_last, fifo_rd, ser_out;
  logic [1:0] link_mode;
  logic [7:0] fifo_data;

  always #2 clk = ~clk;

  hdlc_tx_framer u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bit_en(bit_en), .link_mode(link_mode),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_last(fifo_last),
    .fifo_rd(fifo_rd), .ser_out(ser_out)
  );

  logic [7:0] q_d[$];
  logic       q_l[$];
  logic [7:0] m_d[$];
  logic       m_l[$];
  logic       exp_b[$];
  int         st_ones;
  int         checks = 0, errors = 0, rd_cnt = 0;
  logic       popped = 1'b0;
  bit         finished = 1'b0;

  always @(posedge clk) begin
    popped <= fifo_rd;
    if (fifo_rd) rd_cnt <= rd_cnt + 1;
  end

  always @(negedge clk) begin
    if (popped && q_d.size() > 0) begin
      void'(q_d.pop_front());
      void'(q_l.pop_front());
    end
    fifo_empty = (q_d.size() == 0);
    fifo_data  = (q_d.size() > 0) ? q_d[0] : 8'h00;
    fifo_last  = (q_l.size() > 0) ? q_l[0] : 1'b0;
  end

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] crc8(logic [15:0] c, logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = c[0] ^ b[i];
      c  = c >> 1;
      if (fb) c = c ^ 16'h8408;
    end
    return c;
  endfunction

  function automatic void push_raw(logic [7:0] b);
    for (int i = 0; i < 8; i++) exp_b.push_back(b[i]);
    st_ones = 0;
  endfunction

  function automatic void push_st(logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      exp_b.push_back(b[i]);
      st_ones = b[i] ? st_ones + 1 : 0;
      if (st_ones == 5) begin
        exp_b.push_back(1'b0);
        st_ones = 0;
      end
    end
  endfunction

  function automatic void build_exp(int mode, int nbits);
    int idx = 0;
    int n = m_d.size();
    logic [15:0] c;
    bit done;
    exp_b.delete();
    st_ones = 0;
    push_raw(8'hFF);
    while (exp_b.size() < nbits) begin
      if (mode == 2) push_raw(8'hFE);
      else if (mode == 3) begin
        if (idx < n) begin push_raw(m_d[idx]); idx++; end
        else push_raw(8'hFF);
      end else if (idx < n) begin
        push_raw(8'h7E);
        c = 16'hFFFF;
        done = 0;
        while (idx < n && !done) begin
          push_st(m_d[idx]);
          c = crc8(c, m_d[idx]);
          done = m_l[idx];
          idx++;
        end
        if (done) begin
          c = ~c;
          push_st(c[7:0]);
          push_st(c[15:8]);
          push_raw(8'h7E);
        end else push_raw(8'hFF);
      end else push_raw(mode == 1 ? 8'h7E : 8'hFF);
    end
  endfunction

  task automatic clear_fifo();
    tx_en = 1'b0;
    bit_en = 1'b0;
    q_d.delete(); q_l.delete(); m_d.delete(); m_l.delete();
    repeat (3) @(negedge clk);
  endtask

  task automatic put(logic [7:0] b, logic l);
    q_d.push_back(b); q_l.push_back(l);
    m_d.push_back(b); m_l.push_back(l);
  endtask

  task automatic enable(int mode);
    link_mode = 2'(mode);
    repeat (2) @(negedge clk);
    tx_en = 1'b1;
  endtask

  // drive nbits strobes; compare with exp_b where present
  task automatic run_cmp(string req, int nbits);
    int bad = -1, act = 0, e = 0, unstable = 0;
    for (int i = 0; i < nbits; i++) begin
      logic b;
      int g;
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      b = ser_out;
      if (i < exp_b.size() && bad < 0 && b !== exp_b[i]) begin
        bad = i; act = int'(b); e = int'(exp_b[i]);
      end
      g = $urandom_range(0, 2);
      repeat (g) begin
        @(negedge clk);
        if (ser_out !== b) unstable++;
      end
    end
    if (exp_b.size() > 0) check(bad < 0, req, $sformatf("bit %0d of stream", bad), act, e);
    check(unstable == 0, "R12", "changes between strobes", unstable, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int r0;
    void'($urandom(32'h5EED));
    rst_n = 1'b0; tx_en = 1'b0; bit_en = 1'b0; link_mode = 2'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(ser_out === 1'b1, "R1", "ser_out after reset", int'(ser_out), 1);
    check(fifo_rd === 1'b0, "R1", "fifo_rd after reset", int'(fifo_rd), 0);

    // R2: mark idle
    clear_fifo(); build_exp(0, 32); enable(0); run_cmp("R2", 32);

    // R3: flag fill
    clear_fifo(); build_exp(1, 40); enable(1); run_cmp("R1 R3", 40);

    // R4: go-ahead holds queued packet
    clear_fifo(); put(8'h11, 0); put(8'h22, 1);
    build_exp(2, 40); r0 = rd_cnt; enable(2); run_cmp("R4", 40);
    check(rd_cnt == r0, "R4", "reads in go-ahead", rd_cnt - r0, 0);
    link_mode = 2'd0; exp_b.delete(); run_cmp("R4", 120);
    check(q_d.size() == 0, "R4", "entries left after leaving go-ahead", q_d.size(), 0);

    // R5 R6 R8: packet with stuffing inside data
    clear_fifo(); put(8'hFF, 0); put(8'h7E, 0); put(8'h1F, 1);
    build_exp(0, 120); enable(0); run_cmp("R2 R5 R6 R8", 120);

    // R7: back-to-back packets in fill
    clear_fifo(); put(8'hA5, 0); put(8'h3C, 1); put(8'hF8, 1);
    build_exp(1, 160); enable(1); run_cmp("R3 R6 R7", 160);

    // R9: raw pass-through
    clear_fifo(); put(8'hFF, 0); put(8'hFF, 1); put(8'h3E, 0);
    build_exp(3, 64); enable(3); run_cmp("R9", 64);

    // R10: abort when FIFO runs dry
    clear_fifo(); put(8'h55, 0); put(8'hFF, 0);
    build_exp(1, 80); enable(1); run_cmp("R10", 80);

    // R11: disable mid-packet
    clear_fifo();
    for (int i = 0; i < 6; i++) put(8'(i * 37 + 5), i == 5);
    exp_b.delete(); enable(1); run_cmp("R11", 30);
    tx_en = 1'b0; r0 = rd_cnt;
    begin
      int hi = 0;
      for (int i = 0; i < 12; i++) begin
        bit_en = i[0];
        @(negedge clk);
        if (ser_out !== 1'b1) hi++;
      end
      bit_en = 1'b0;
      check(hi == 0, "R11", "non-one bits while disabled", hi, 0);
    end
    check(rd_cnt == r0, "R11", "reads while disabled", rd_cnt - r0, 0);
    clear_fifo(); build_exp(1, 24); enable(1); run_cmp("R1 R11", 24);

    // random packets
    for (int it = 0; it < 16; it++) begin
      int mode, npk, total;
      mode = $urandom_range(0, 2);
      if (mode == 2) mode = 3;
      npk = $urandom_range(1, 3);
      total = 0;
      clear_fifo();
      for (int p = 0; p < npk; p++) begin
        int len;
        bit drop;
        len = $urandom_range(1, 5);
        drop = (p == npk - 1) && ($urandom_range(0, 4) == 0);
        for (int k = 0; k < len; k++) begin
          logic [7:0] b;
          b = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom());
          put(b, (k == len - 1) && !drop);
          total++;
        end
      end
      build_exp(mode, 16 * total + 40 * npk + 64);
      enable(mode);
      run_cmp("R5 R6 R7 R8 R9 R10", 16 * total + 40 * npk + 64);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule